// File: doc/BRIEF.md
# Orbit Drift Interlock Timer

This block guards a section of beam line against slow orbit drift. Two position monitors report to it: one upstream and one downstream. Each report carries, for each monitor, a flag saying that data came in, a flag saying that the orbit in it is usable, and a signed position. The block compares each usable position with that monitor's own programmable window. It then runs three consecutive-period timers, one for each fault class. When a timer reaches its programmed limit, the block latches a beam-dump request together with a cause code.

Evaluation is paced by an external `tick` pulse. The pulse can come once per second in operation or once per millisecond in tests. All reports that arrive during a period are merged into that period's verdict, and this includes a report that arrives in the same cycle as the tick. The fault classes are:
- both watched monitors out of tolerance;
- no data at all;
- data present but no usable orbit.

The loss of a single monitor raises no fault of its own. The out-of-tolerance rule then runs on the remaining monitor alone. The request stays set until `clr` is pulsed.

Top module: `orbit_drift_interlock`

## Requirements
- R1: When every monitor with a usable orbit in a period is out of tolerance, for `lim_oot` consecutive ticks, `dump_req` rises with `dump_cause` = 2'b01 after the edge that registers the last of those ticks.
- R2: A period in which only one monitor delivers data raises no fault by itself. The out-of-tolerance rule of R1 then applies to the remaining monitor alone. In `rpt_data_ok` and `rpt_orbit_ok`, bit 0 is upstream and bit 1 is downstream.
- R3: When neither monitor delivers data for `lim_nodata` consecutive ticks, the request latches with cause 2'b10.
- R4: When data arrives but neither monitor carries a usable orbit for `lim_inval` consecutive ticks, the request latches with cause 2'b11.
- R5: Each timer returns to zero at any tick where its condition is absent. A fault must therefore persist for the full limit again after any break.
- R6: A position counts as in tolerance when it lies between the monitor's signed lower and upper bounds, both bounds included. A position one step outside either bound is out of tolerance.
- R7: Once latched, `dump_req` and `dump_cause` hold until `clr`, whatever faults follow.
- R8: `clr` drops the request, sets the cause to 2'b00 and zeroes all timers, whether or not a tick is present.
- R9: During and after reset `dump_req` is 0 and `dump_cause` is 2'b00.
- R10: When both monitors carry usable orbits and only one of them is out of tolerance, the out-of-tolerance timer does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Evaluation-period pulse |
| rpt_stb | input | 1 | A report is present this cycle |
| rpt_data_ok | input | 2 | Per-monitor data present (bit 0 upstream) |
| rpt_orbit_ok | input | 2 | Per-monitor usable orbit (bit 0 upstream) |
| rpt_pos_up | input | POS_W | Upstream position, signed |
| rpt_pos_dn | input | POS_W | Downstream position, signed |
| tol_lo_up | input | POS_W | Upstream lower bound, signed |
| tol_hi_up | input | POS_W | Upstream upper bound, signed |
| tol_lo_dn | input | POS_W | Downstream lower bound, signed |
| tol_hi_dn | input | POS_W | Downstream upper bound, signed |
| lim_oot | input | CNT_W | Ticks before an out-of-tolerance dump |
| lim_nodata | input | CNT_W | Ticks before a no-data dump |
| lim_inval | input | CNT_W | Ticks before an invalid-orbit dump |
| clr | input | 1 | Clears the latched request and the timers |
| dump_req | output | 1 | Latched beam-dump request |
| dump_cause | output | 2 | 01 out of tolerance, 10 no data, 11 invalid orbit |

## Verification
The hardest situation to bring about from the ports is a change of fault class: one timer runs partway, and then its condition turns into a different fault. The earlier timer must restart, and the new one must not inherit any of its count. The stimulus table walks periods in which a no-data run is broken by a single data-present but unusable report, and in which a one-monitor drift runs straight into a clear. Shortened limits let each run reach its exact threshold within a few periods, so the cycle in which the request rises is checked at both sides of the limit.

// File: rtl/odi_pkg.sv
package odi_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_OOT    = 2'b01,
    CAUSE_NODATA = 2'b10,
    CAUSE_INVAL  = 2'b11
  } cause_e;

  localparam int N_MON = 2;  // upstream, downstream
  localparam int N_FLT = 3;  // out of tolerance, no data, invalid orbit
  localparam int F_OOT    = 0;
  localparam int F_NODATA = 1;
  localparam int F_INVAL  = 2;
endpackage

// File: rtl/odi_mon_track.sv
// Per-monitor period accumulator: records during one evaluation period
// whether data, a usable orbit, and an in-window orbit were seen.
module odi_mon_track #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stb,
  input  logic             data_ok,
  input  logic             orbit_ok,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] lo,
  input  logic [POS_W-1:0] hi,
  output logic             present,
  output logic             orbit_vld,
  output logic             out_tol
);
  logic seen_data_q, seen_orb_q, seen_in_q;
  logic seen_data_d, seen_orb_d, seen_in_d;
  logic new_data, new_orb, in_win;

  assign in_win   = ($signed(pos) >= $signed(lo)) && ($signed(pos) <= $signed(hi));
  assign new_data = stb & data_ok;
  assign new_orb  = new_data & orbit_ok;

  // Effective period view includes a report arriving with the tick.
  assign present   = seen_data_q | new_data;
  assign orbit_vld = seen_orb_q | new_orb;
  assign out_tol   = orbit_vld & ~(seen_in_q | (new_orb & in_win));

  always_comb begin
    if (tick) begin
      seen_data_d = 1'b0;
      seen_orb_d  = 1'b0;
      seen_in_d   = 1'b0;
    end else begin
      seen_data_d = present;
      seen_orb_d  = orbit_vld;
      seen_in_d   = seen_in_q | (new_orb & in_win);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_data_q <= 1'b0;
      seen_orb_q  <= 1'b0;
      seen_in_q   <= 1'b0;
    end else begin
      seen_data_q <= seen_data_d;
      seen_orb_q  <= seen_orb_d;
      seen_in_q   <= seen_in_d;
    end
  end

  // R6: an in-window orbit seen earlier in the period keeps the monitor in tolerance
  assert_inwin_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && new_orb && in_win) |=> !out_tol);
endmodule

// File: rtl/odi_fault_timer.sv
// Consecutive-period counter for one fault condition.
module odi_fault_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cond,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign fire    = tick & cond & ~clr & (cnt_inc >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cond ? cnt_inc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: a tick without the condition restarts the count
  assert_timer_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cond) |=> (cnt_q == '0));
  // R8: clear leaves the count at zero
  assert_timer_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/orbit_drift_interlock.sv
module orbit_drift_interlock
  import odi_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rpt_stb,
  input  logic [1:0]       rpt_data_ok,
  input  logic [1:0]       rpt_orbit_ok,
  input  logic [POS_W-1:0] rpt_pos_up,
  input  logic [POS_W-1:0] rpt_pos_dn,
  input  logic [POS_W-1:0] tol_lo_up,
  input  logic [POS_W-1:0] tol_hi_up,
  input  logic [POS_W-1:0] tol_lo_dn,
  input  logic [POS_W-1:0] tol_hi_dn,
  input  logic [CNT_W-1:0] lim_oot,
  input  logic [CNT_W-1:0] lim_nodata,
  input  logic [CNT_W-1:0] lim_inval,
  input  logic             clr,
  output logic             dump_req,
  output logic [1:0]       dump_cause
);
  logic [POS_W-1:0] pos_a [N_MON];
  logic [POS_W-1:0] lo_a  [N_MON];
  logic [POS_W-1:0] hi_a  [N_MON];
  logic [CNT_W-1:0] lim_a [N_FLT];
  logic [N_MON-1:0] present, orbv, outt;
  logic [N_FLT-1:0] cond, fire;

  assign pos_a[0] = rpt_pos_up;  assign pos_a[1] = rpt_pos_dn;
  assign lo_a[0]  = tol_lo_up;   assign lo_a[1]  = tol_lo_dn;
  assign hi_a[0]  = tol_hi_up;   assign hi_a[1]  = tol_hi_dn;
  assign lim_a[F_OOT]    = lim_oot;
  assign lim_a[F_NODATA] = lim_nodata;
  assign lim_a[F_INVAL]  = lim_inval;

  for (genvar m = 0; m < N_MON; m++) begin : g_mon
    odi_mon_track #(.POS_W(POS_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stb(rpt_stb),
      .data_ok(rpt_data_ok[m]), .orbit_ok(rpt_orbit_ok[m]),
      .pos(pos_a[m]), .lo(lo_a[m]), .hi(hi_a[m]),
      .present(present[m]), .orbit_vld(orbv[m]), .out_tol(outt[m])
    );
  end

  // Fault classes are mutually exclusive by construction of the period view.
  logic any_data, any_orb, all_out;
  assign any_data = |present;
  assign any_orb  = |orbv;
  assign all_out  = any_orb & (&(~orbv | outt));

  assign cond[F_OOT]    = all_out;
  assign cond[F_NODATA] = ~any_data;
  assign cond[F_INVAL]  = any_data & ~any_orb;

  for (genvar f = 0; f < N_FLT; f++) begin : g_tmr
    odi_fault_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond[f]),
      .clr(clr), .limit(lim_a[f]), .fire(fire[f])
    );
  end

  // Dump latch: next-state and register processes.
  logic   req_q, req_d;
  cause_e cause_q, cause_d;

  always_comb begin
    req_d   = req_q;
    cause_d = cause_q;
    if (clr) begin
      req_d   = 1'b0;
      cause_d = CAUSE_NONE;
    end else if (!req_q && |fire) begin
      req_d = 1'b1;
      if (fire[F_OOT])         cause_d = CAUSE_OOT;
      else if (fire[F_NODATA]) cause_d = CAUSE_NODATA;
      else                     cause_d = CAUSE_INVAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign dump_req   = req_q;
  assign dump_cause = cause_q;

  // R1 R3 R4: at most one fault class can expire in a period
  assert_single_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));
  // R7: latched request and cause hold until clear
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_req && !clr) |=> (dump_req && $stable(dump_cause)));
  // R8: clear drops the request
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!dump_req && dump_cause == 2'b00));
  // R9: request and cause agree
  assert_cause_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_req == (dump_cause != 2'b00));
  // R1: a request only rises on an evaluation tick
  assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_req) |-> $past(tick));
endmodule

// File: tb/orbit_drift_interlock_tb.sv
module orbit_drift_interlock_tb;
  localparam int CYC = 5;  // 200 MHz

  logic clk = 1'b0;
  logic rst_n, tick, rpt_stb, clr;
  logic [1:0] rpt_data_ok, rpt_orbit_ok;
  logic signed [15:0] rpt_pos_up, rpt_pos_dn;
  logic [15:0] tol_lo_up, tol_hi_up, tol_lo_dn, tol_hi_dn;
  logic [15:0] lim_oot, lim_nodata, lim_inval;
  logic dump_req;
  logic [1:0] dump_cause;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CYC/2.0) clk = ~clk;

  orbit_drift_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rpt_stb(rpt_stb),
    .rpt_data_ok(rpt_data_ok), .rpt_orbit_ok(rpt_orbit_ok),
    .rpt_pos_up(rpt_pos_up), .rpt_pos_dn(rpt_pos_dn),
    .tol_lo_up(tol_lo_up), .tol_hi_up(tol_hi_up),
    .tol_lo_dn(tol_lo_dn), .tol_hi_dn(tol_hi_dn),
    .lim_oot(lim_oot), .lim_nodata(lim_nodata), .lim_inval(lim_inval),
    .clr(clr), .dump_req(dump_req), .dump_cause(dump_cause)
  );

  typedef struct packed {
    logic              clr;
    logic [1:0]        dat;
    logic [1:0]        orb;
    logic signed [15:0] pu;
    logic signed [15:0] pd;
    logic              req;
    logic [1:0]        cause;
  } vec_t;

  // One row per evaluation period. Limits: oot 3, nodata 4, inval 2.
  // Windows: up [-100,100], dn [-50,50].
  localparam vec_t TBL [23] = '{
    '{1'b0, 2'b11, 2'b11,  16'sd10,   16'sd10,  1'b0, 2'd0}, // R1 in tol
    '{1'b0, 2'b11, 2'b11,  16'sd200, -16'sd60,  1'b0, 2'd0}, // R1 cnt 1
    '{1'b0, 2'b11, 2'b11,  16'sd200, -16'sd60,  1'b0, 2'd0}, // R1 cnt 2
    '{1'b0, 2'b11, 2'b11,  16'sd200,  16'sd50,  1'b0, 2'd0}, // R10 R5 R6 dn at bound
    '{1'b0, 2'b11, 2'b11, -16'sd300,  16'sd60,  1'b0, 2'd0}, // R5 restart 1
    '{1'b0, 2'b11, 2'b11, -16'sd300,  16'sd60,  1'b0, 2'd0}, // 2
    '{1'b0, 2'b11, 2'b11, -16'sd300,  16'sd60,  1'b1, 2'd1}, // R1 fire
    '{1'b1, 2'b11, 2'b11,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R8
    '{1'b0, 2'b01, 2'b01, -16'sd101,  16'sd0,   1'b0, 2'd0}, // R2 R6 one step out
    '{1'b0, 2'b01, 2'b01, -16'sd101,  16'sd0,   1'b0, 2'd0}, // R2
    '{1'b0, 2'b01, 2'b01, -16'sd101,  16'sd0,   1'b1, 2'd1}, // R2 fire on one monitor
    '{1'b1, 2'b01, 2'b01, -16'sd100,  16'sd0,   1'b0, 2'd0}, // R2 R6 at bound
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R3 1
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R3 2
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R3 3
    '{1'b0, 2'b01, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R5 break
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R3 1
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // 2
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // 3
    '{1'b0, 2'b00, 2'b00,  16'sd0,    16'sd0,   1'b1, 2'd2}, // R3 fire
    '{1'b0, 2'b11, 2'b11,  16'sd200, -16'sd60,  1'b1, 2'd2}, // R7 hold
    '{1'b1, 2'b11, 2'b00,  16'sd0,    16'sd0,   1'b0, 2'd0}, // R4 1
    '{1'b0, 2'b11, 2'b00,  16'sd0,    16'sd0,   1'b1, 2'd3}  // R4 fire
  };

  task automatic check(input string req, input logic r, input logic [1:0] c,
                       input logic er, input logic [1:0] ec);
    n_chk++;
    if (r !== er || c !== ec) begin
      n_fail++;
      $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d", req, r, c, er, ec);
    end
  endtask

  task automatic do_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic report(input logic [1:0] d, input logic [1:0] o,
                        input logic signed [15:0] pu, input logic signed [15:0] pd,
                        input logic with_tick);
    @(negedge clk);
    rpt_stb = 1'b1; rpt_data_ok = d; rpt_orbit_ok = o;
    rpt_pos_up = pu; rpt_pos_dn = pd; tick = with_tick;
    @(negedge clk);
    rpt_stb = 1'b0; tick = 1'b0;
  endtask

  task automatic tick_only();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; rpt_stb = 1'b0; clr = 1'b0;
    rpt_data_ok = '0; rpt_orbit_ok = '0; rpt_pos_up = '0; rpt_pos_dn = '0;
    tol_lo_up = -16'sd100; tol_hi_up = 16'sd100;
    tol_lo_dn = -16'sd50;  tol_hi_dn = 16'sd50;
    lim_oot = 16'd3; lim_nodata = 16'd4; lim_inval = 16'd2;
    repeat (3) @(negedge clk);
    check("R9 in reset", dump_req, dump_cause, 1'b0, 2'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 after reset", dump_req, dump_cause, 1'b0, 2'd0);

    for (int i = 0; i < 23; i++) begin
      if (TBL[i].clr) do_clr();
      if (TBL[i].dat != 2'b00) report(TBL[i].dat, TBL[i].orb, TBL[i].pu, TBL[i].pd, 1'b0);
      tick_only();
      check($sformatf("table row %0d", i), dump_req, dump_cause, TBL[i].req, TBL[i].cause);
    end

    // R7: further no-data periods past the limit keep the invalid-orbit cause
    for (int k = 0; k < 5; k++) tick_only();
    check("R7 hold across faults", dump_req, dump_cause, 1'b1, 2'd3);

    // R8: clear without tick
    do_clr();
    check("R8 clear without tick", dump_req, dump_cause, 1'b0, 2'd0);

    // R1: report in the same cycle as the tick counts for that period
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    check("R1 same-cycle report below limit", dump_req, dump_cause, 1'b0, 2'd0);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    check("R1 same-cycle report at limit", dump_req, dump_cause, 1'b1, 2'd1);

    // R6: an in-window report earlier in the period clears the period's fault
    do_clr();
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    report(2'b01, 2'b01, 16'sd100, 16'sd0, 1'b0);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    check("R6 in-window earlier in period", dump_req, dump_cause, 1'b0, 2'd0);

    // R9: reset in the middle of a latched request
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    report(2'b11, 2'b11, 16'sd150, -16'sd70, 1'b1);
    check("R1 fire before reset", dump_req, dump_cause, 1'b1, 2'd1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset", dump_req, dump_cause, 1'b0, 2'd0);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule